// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits beside a memory slave and watches its accepted read and write address handshakes. An exclusive read makes a reservation: the block records the address, reduced to a granule, against the transaction ID that issued it. When an exclusive write arrives later, the block checks whether that ID still holds a reservation for the same granule. If it does, the write may update memory and receives EXOKAY. If it does not, the write receives OKAY and an inhibit flag tells the slave to drop the memory update.

Each ID has at most one reservation, held in a small table of parameterised depth. A reservation is removed when a write from a different ID lands on its granule, or when the ID's own exclusive write succeeds. It is replaced when the same ID issues another exclusive read. When the table is full, a reservation for a new ID takes the slot of the least recently reserved entry.

Every accepted write produces exactly one result, one cycle after it is accepted. If a read and a write are accepted in the same cycle, the write is judged against the table as it stood before that edge. The read's reservation takes priority over any clearing of the same slot.

Top module: `excl_monitor`

## Requirements
- R1: After an exclusive read from ID X to address A, an exclusive write from X to the granule of A gets res_resp = 2'b01 (EXOKAY) and res_inhibit = 0, provided nothing removed the reservation in between.
- R2: An exclusive write from an ID with no reservation, or whose reservation covers a different granule, gets res_resp = 2'b00 (OKAY) and res_inhibit = 1.
- R3: An accepted write, normal or exclusive, from an ID other than X to the reserved granule of X removes X's reservation.
- R4: A successful exclusive write removes the writer's own reservation, so a repeat of that write fails.
- R5: A new exclusive read from an ID replaces its earlier reservation. The old address then fails and the new one succeeds.
- R6: A normal write (aw_excl = 0) gets res_resp = 2'b00 and res_inhibit = 0, and it does not remove a reservation held by its own ID.
- R7: With all ENTRIES slots valid, an exclusive read from an ID not in the table evicts the entry whose last reservation is oldest. Both a first reservation and a replacement count as reserving.
- R8: Addresses are compared only above the GRAN_W least significant bits, so addresses inside one 2^GRAN_W-byte granule match.
- R9: res_valid is high for exactly the cycle after each accepted write and low at all other times, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_fire | input | 1 | Read address accepted this cycle |
| ar_id | input | ID_W | Read transaction ID |
| ar_addr | input | ADDR_W | Read address |
| ar_excl | input | 1 | Read is exclusive |
| aw_fire | input | 1 | Write address accepted this cycle |
| aw_id | input | ID_W | Write transaction ID |
| aw_addr | input | ADDR_W | Write address |
| aw_excl | input | 1 | Write is exclusive |
| res_valid | output | 1 | Result for the write accepted in the previous cycle |
| res_resp | output | 2 | 2'b01 exclusive success, 2'b00 otherwise |
| res_inhibit | output | 1 | Suppress the memory update of that write |

## Verification
Table updates become visible on the clock edge that accepts a read or write. A write's result is registered, so it appears on the outputs one cycle after the edge that accepted the write. The bench drives each operation for one cycle starting at a falling edge and, in the same step, pushes the expected response and inhibit value into a queue. A monitor pops that item and compares it at the next falling edge on which res_valid is high. This places each comparison exactly one register stage after its stimulus. A result that appears with nothing queued, or a queue that still holds items at the end, counts as a mismatch.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } resp_e;
endpackage

// File: rtl/excl_match.sv
// Compares one query (ID, granule tag) against every table slot.
module excl_match #(
  parameter int ENTRIES = 4,
  parameter int ID_W    = 4,
  parameter int TAG_W   = 30
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][ID_W-1:0]  ids,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [ID_W-1:0]               q_id,
  input  logic [TAG_W-1:0]              q_tag,
  output logic [ENTRIES-1:0]            id_hit,
  output logic [ENTRIES-1:0]            tag_hit
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign id_hit[i]  = valid[i] && (ids[i] == q_id);
    assign tag_hit[i] = valid[i] && (tags[i] == q_tag);
  end
endmodule

// File: rtl/excl_victim.sv
// Picks the slot for a reservation: same ID, else a free slot, else the oldest.
module excl_victim #(
  parameter int ENTRIES = 4,
  parameter int ID_W    = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][ID_W-1:0]  ids,
  input  logic [ENTRIES-1:0][IDX_W-1:0] ranks,
  input  logic [ID_W-1:0]               q_id,
  output logic [IDX_W-1:0]              slot
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] own_idx, free_idx, old_idx;
  logic             own_found, free_found;

  always_comb begin
    own_idx    = '0;
    free_idx   = '0;
    old_idx    = '0;
    own_found  = 1'b0;
    free_found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid[i] && ids[i] == q_id) begin
        own_idx   = IDX_W'(i);
        own_found = 1'b1;
      end
      if (!valid[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
      if (ranks[i] == OLDEST) old_idx = IDX_W'(i);
    end
    if (own_found)       slot = own_idx;
    else if (free_found) slot = free_idx;
    else                 slot = old_idx;
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 4,
  parameter int GRAN_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_fire,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic              ar_excl,
  input  logic              aw_fire,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              aw_excl,
  output logic              res_valid,
  output logic [1:0]        res_resp,
  output logic              res_inhibit
);
  localparam int TAG_W = ADDR_W - GRAN_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][ID_W-1:0]  ent_id;
  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
  logic [ENTRIES-1:0][IDX_W-1:0] ent_rank;

  logic [TAG_W-1:0]   aw_tag, ar_tag;
  logic [ENTRIES-1:0] w_id_hit, w_tag_hit, own_hit, clr;
  logic [IDX_W-1:0]   slot;
  logic               pass, install;

  assign aw_tag = aw_addr[ADDR_W-1:GRAN_W];
  assign ar_tag = ar_addr[ADDR_W-1:GRAN_W];

  excl_match #(.ENTRIES(ENTRIES), .ID_W(ID_W), .TAG_W(TAG_W)) i_wmatch (
    .valid(ent_valid), .ids(ent_id), .tags(ent_tag),
    .q_id(aw_id), .q_tag(aw_tag),
    .id_hit(w_id_hit), .tag_hit(w_tag_hit)
  );

  excl_victim #(.ENTRIES(ENTRIES), .ID_W(ID_W), .IDX_W(IDX_W)) i_victim (
    .valid(ent_valid), .ids(ent_id), .ranks(ent_rank),
    .q_id(ar_id), .slot(slot)
  );

  assign own_hit = w_id_hit & w_tag_hit;
  assign pass    = aw_excl && (|own_hit);
  assign install = ar_fire && ar_excl;

  // Other-ID writes to the granule clear; a passing exclusive clears its own.
  assign clr = aw_fire ? ((w_tag_hit & ~w_id_hit) | (pass ? own_hit : '0)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_resp    <= RESP_OKAY;
      res_inhibit <= 1'b0;
      ent_valid   <= '0;
      ent_id      <= '0;
      ent_tag     <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_rank[i] <= IDX_W'(i);
    end else begin
      res_valid   <= aw_fire;
      res_resp    <= (aw_fire && pass) ? RESP_EXOKAY : RESP_OKAY;
      res_inhibit <= aw_fire && aw_excl && !pass;
      for (int i = 0; i < ENTRIES; i++) begin
        if (clr[i]) ent_valid[i] <= 1'b0;
        if (install && slot == IDX_W'(i)) begin
          ent_valid[i] <= 1'b1;
          ent_id[i]    <= ar_id;
          ent_tag[i]   <= ar_tag;
          ent_rank[i]  <= '0;
        end else if (install && ent_rank[i] < ent_rank[slot]) begin
          ent_rank[i]  <= ent_rank[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ar_fire,
  input logic [ID_W-1:0]   ar_id,
  input logic [ADDR_W-1:0] ar_addr,
  input logic              ar_excl,
  input logic              aw_fire,
  input logic [ID_W-1:0]   aw_id,
  input logic [ADDR_W-1:0] aw_addr,
  input logic              aw_excl,
  input logic              res_valid,
  input logic [1:0]        res_resp,
  input logic              res_inhibit
);
  logic seen_xrd;
  always_ff @(posedge clk) begin
    if (rst) seen_xrd <= 1'b0;
    else if (ar_fire && ar_excl) seen_xrd <= 1'b1;
  end

  assert_result_due_R9: assert property (@(posedge clk) disable iff (rst)
    aw_fire |=> res_valid);
  assert_no_stray_result_R9: assert property (@(posedge clk) disable iff (rst)
    !aw_fire |=> !res_valid);
  assert_normal_write_plain_R6: assert property (@(posedge clk) disable iff (rst)
    (aw_fire && !aw_excl) |=> (res_resp == 2'b00 && !res_inhibit));
  assert_no_reservation_fails_R2: assert property (@(posedge clk) disable iff (rst)
    (aw_fire && aw_excl && !seen_xrd && !ar_fire) |=> (res_inhibit && res_resp == 2'b00));
  assert_inhibit_only_on_fail_R2: assert property (@(posedge clk) disable iff (rst)
    res_inhibit |-> (res_valid && res_resp == 2'b00));
  assert_back_to_back_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (aw_fire && aw_excl && $past(ar_fire && ar_excl && !aw_fire) &&
     aw_id == $past(ar_id) &&
     aw_addr[ADDR_W-1:GRAN_W] == $past(ar_addr[ADDR_W-1:GRAN_W]))
    |=> (res_resp == 2'b01 && !res_inhibit));
endmodule

bind excl_monitor excl_monitor_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) i_chk (
  .clk(clk), .rst(rst),
  .ar_fire(ar_fire), .ar_id(ar_id), .ar_addr(ar_addr), .ar_excl(ar_excl),
  .aw_fire(aw_fire), .aw_id(aw_id), .aw_addr(aw_addr), .aw_excl(aw_excl),
  .res_valid(res_valid), .res_resp(res_resp), .res_inhibit(res_inhibit)
);

// File: tb/test_excl_monitor.sv
module test_excl_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ar_fire = 0, ar_excl = 0, aw_fire = 0, aw_excl = 0;
  logic [ID_W-1:0]   ar_id = '0, aw_id = '0;
  logic [ADDR_W-1:0] ar_addr = '0, aw_addr = '0;
  logic              res_valid, res_inhibit;
  logic [1:0]        res_resp;

  excl_monitor i_excl_monitor (
    .clk(clk), .rst(rst),
    .ar_fire(ar_fire), .ar_id(ar_id), .ar_addr(ar_addr), .ar_excl(ar_excl),
    .aw_fire(aw_fire), .aw_id(aw_id), .aw_addr(aw_addr), .aw_excl(aw_excl),
    .res_valid(res_valid), .res_resp(res_resp), .res_inhibit(res_inhibit)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [1:0] resp;
    logic       inh;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: one result due one cycle after each accepted write.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R9: unexpected result resp=%b inh=%b, expected none", res_resp, res_inhibit);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (res_resp !== e.resp || res_inhibit !== e.inh) begin
          n_bad++;
          $display("FAIL %s: resp=%b inh=%b expected resp=%b inh=%b",
                   e.req, res_resp, res_inhibit, e.resp, e.inh);
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic xrd(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a);
    ar_fire = 1; ar_excl = 1; ar_id = id; ar_addr = a;
    @(negedge clk);
    ar_fire = 0; ar_excl = 0;
  endtask

  // kind: 0 normal, 1 exclusive expected pass, 2 exclusive expected fail
  task automatic wr(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                    input int kind, input string req);
    exp_t e;
    e.req  = req;
    e.resp = (kind == 1) ? 2'b01 : 2'b00;
    e.inh  = (kind == 2);
    exp_q.push_back(e);
    aw_fire = 1; aw_excl = (kind != 0); aw_id = id; aw_addr = a;
    @(negedge clk);
    aw_fire = 0; aw_excl = 0;
  endtask

  task automatic gap();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    @(negedge clk);
    do_reset();
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: res_valid=%b after reset, expected 0", res_valid);
    end
    // R1 basic pass, R4 repeat fails
    xrd(1, 32'h1000);
    wr(1, 32'h1000, 1, "R1");
    wr(1, 32'h1000, 2, "R4");
    // R2 no reservation, mismatched granule
    wr(2, 32'h2000, 2, "R2");
    xrd(3, 32'h3000);
    wr(3, 32'h3010, 2, "R2");
    wr(3, 32'h3000, 1, "R1");
    gap();
    // R3 normal write by another ID clears
    do_reset();
    xrd(4, 32'h4000);
    wr(5, 32'h4000, 0, "R6");
    wr(4, 32'h4000, 2, "R3");
    // R3 exclusive write by another ID clears
    xrd(4, 32'h4100);
    xrd(6, 32'h4100);
    wr(6, 32'h4100, 1, "R1");
    wr(4, 32'h4100, 2, "R3");
    gap();
    // R5 replacement
    do_reset();
    xrd(7, 32'h5000);
    xrd(7, 32'h5100);
    wr(7, 32'h5000, 2, "R5");
    wr(7, 32'h5100, 1, "R5");
    // R6 same-ID normal write keeps reservation
    xrd(8, 32'h6000);
    wr(8, 32'h6000, 0, "R6");
    wr(8, 32'h6000, 1, "R6");
    // R8 granule
    xrd(9, 32'h0100);
    wr(9, 32'h0103, 1, "R8");
    xrd(9, 32'h0100);
    wr(9, 32'h0104, 2, "R8");
    gap();
    // R7 eviction of oldest
    do_reset();
    xrd(1, 32'h100); xrd(2, 32'h200); xrd(3, 32'h300); xrd(4, 32'h400);
    xrd(5, 32'h500);
    wr(1, 32'h100, 2, "R7");
    wr(2, 32'h200, 1, "R7");
    gap();
    // R7 replacement refreshes age
    do_reset();
    xrd(1, 32'h100); xrd(2, 32'h200); xrd(3, 32'h300); xrd(4, 32'h400);
    xrd(1, 32'h180);
    xrd(5, 32'h500);
    wr(2, 32'h200, 2, "R7");
    wr(1, 32'h180, 1, "R7");
    wr(5, 32'h500, 1, "R7");
    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
    end
    summary();
  end
endmodule